// File: doc/BRIEF.md
# General-Purpose Pin Bank with Set/Clear Output Control

This block controls a bank of up to 64 general-purpose pins through a small register port. The output latch is never written as a whole word. A write to the set register raises the latch bits that carry a 1, and a write to the clear register lowers them. Bits written as 0 are left alone. This lets several agents update different pins without a read-modify-write sequence.

Each pin has its own configuration word with these fields:
- output enable;
- a polarity bit, which inverts both the value driven to the pad and the value read back from the pad;
- an open-drain option;
- two stored interrupt fields;
- a function select field.

A pin whose function select is nonzero belongs to another function. The bank then releases the pad enable and the open-drain control for that pin. A constants register reports the pin count and the interrupt vector base.

The register port has a small control machine with two states, ST_IDLE and ST_RESP. In ST_IDLE the port is ready. A write takes effect at the accepting edge, and the machine stays in ST_IDLE. A read takes the transition ST_IDLE to ST_RESP and captures the read word at that edge. ST_RESP lasts one cycle with the read data valid, then returns unconditionally to ST_IDLE. Requests that arrive during ST_RESP are ignored.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output latch and every configuration word are zero. The pad enable, open-drain and output lines are all 0, `ready` is 1 and `rvalid` is 0.
- R2: A write to byte offset 0x8 sets each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R3: A write to byte offset 0x10 clears each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R4: A read of offset 0x8 returns the output latch. A read of offset 0x10 returns zero.
- R5: A read of offset 0x0 returns the pad inputs as registered one cycle before the accepting edge, each XORed with that pin's polarity bit.
- R6: The configuration word of pin n is at byte offset 0x400 + 8*n. Its fields are:
  - bit 0: output enable;
  - bit 1: polarity;
  - bit 2: interrupt enable;
  - bit 3: interrupt type;
  - bit 12: open-drain;
  - bits 25:16: function select.

  A read returns the stored fields at these positions, and every other bit reads 0.
- R7: `pad_out[n]` equals latch bit n XOR the polarity bit of pin n.
- R8: When a pin's function select is 0 and open-drain is 0, `pad_oe[n]` equals its output enable.
- R9: When a pin's function select is 0 and both output enable and open-drain are 1, `pad_od[n]` is 1. In that case `pad_oe[n]` is 1 only while `pad_out[n]` is 0.
- R10: A pin whose function select is nonzero has `pad_oe` and `pad_od` held at 0.
- R11: A read of offset 0x90 returns the pin count in bits 7:0 and the vector base in bits 15:8, with zeros above.
- R12: A read accepted in ST_IDLE gives `rvalid` high for exactly the next cycle, with `ready` low in that cycle. A request presented while `ready` is low has no effect.
- R13: Reads of unmapped offsets return zero, and writes to them change nothing. Unmapped offsets include configuration slots at or beyond the pin count and writes to offset 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte offset; bits 2:0 are ignored |
| wdata | input | 64 | Write data |
| ready | output | 1 | Port is in ST_IDLE and will accept a request |
| rvalid | output | 1 | Read data valid (ST_RESP) |
| rdata | output | 64 | Read data |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Value driven to pads |
| pad_oe | output | NPINS | Pad drive enable |
| pad_od | output | NPINS | Pad open-drain mode |

## Verification
The assertions assume that `req`, `we`, `addr` and `wdata` are stable from the falling edge through the next rising edge. They also assume that no request is treated as accepted unless `ready` is high.

The stimulus drives all inputs only on falling edges. It holds `req` for one rising edge and releases it before the next access. One directed case deliberately presents a write while `ready` is low, to confirm that the request is ignored.

Random configuration words keep the function select at zero most of the time, so that pad behaviour is exercised on live pins.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_state_t;

    typedef struct packed {
        logic [9:0] fsel;
        logic       odrain;
        logic       irq_edge;
        logic       irq_on;
        logic       invert;
        logic       drive_en;
    } pin_cfg_t;

    // 8-byte word indices of the register map
    localparam int W_INPUT = 0;
    localparam int W_SET   = 1;
    localparam int W_CLR   = 2;
    localparam int W_CONST = 18;
    localparam int W_CFG   = 128;

    function automatic pin_cfg_t word_to_cfg(input logic [63:0] w);
        pin_cfg_t c;
        c.drive_en = w[0];
        c.invert   = w[1];
        c.irq_on   = w[2];
        c.irq_edge = w[3];
        c.odrain   = w[12];
        c.fsel     = w[25:16];
        return c;
    endfunction

    function automatic logic [63:0] cfg_to_word(input pin_cfg_t c);
        logic [63:0] w;
        w        = '0;
        w[0]     = c.drive_en;
        w[1]     = c.invert;
        w[2]     = c.irq_on;
        w[3]     = c.irq_edge;
        w[12]    = c.odrain;
        w[25:16] = c.fsel;
        return w;
    endfunction

endpackage

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
    import gpio_pkg::*;
#(
    parameter int NPINS = 64,
    localparam int IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  pin_cfg_t      wr_cfg,
    output pin_cfg_t      cfg [NPINS]
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[p] <= '0;
            end else if (wr_en && (wr_idx == IW'(p))) begin
                cfg[p] <= wr_cfg;
            end
        end
    end

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_pkg::*;
#(
    parameter int NPINS = 64
) (
    input  pin_cfg_t         cfg [NPINS],
    input  logic [NPINS-1:0] latch,
    input  logic [NPINS-1:0] in_q,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_od,
    output logic [NPINS-1:0] in_view
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic owned;
        logic level;
        assign owned      = (cfg[p].fsel == '0);
        assign level      = latch[p] ^ cfg[p].invert;
        assign pad_out[p] = level;
        assign pad_od[p]  = owned & cfg[p].drive_en & cfg[p].odrain;
        assign pad_oe[p]  = owned & cfg[p].drive_en & (~cfg[p].odrain | ~level);
        assign in_view[p] = in_q[p] ^ cfg[p].invert;
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int         NPINS    = 64,
    parameter int         AW       = 12,
    parameter logic [7:0] VEC_BASE = 8'd48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [63:0]      wdata,
    output logic             ready,
    output logic             rvalid,
    output logic [63:0]      rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_od
);

    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int WW = AW - 3;

    port_state_t      state_q, state_d;
    logic             accept;
    logic [WW-1:0]    word;
    logic [WW-1:0]    cfg_off;
    logic             hit_set, hit_clr, hit_in, hit_const, hit_cfg;
    logic [IW-1:0]    cfg_idx;
    logic [NPINS-1:0] out_latch;
    logic [NPINS-1:0] in_q;
    logic [NPINS-1:0] in_view;
    logic [63:0]      rd_word;
    logic [63:0]      rdata_q;
    pin_cfg_t         cfg [NPINS];

    assign accept    = req && (state_q == ST_IDLE);
    assign word      = addr[AW-1:3];
    assign hit_in    = (word == WW'(W_INPUT));
    assign hit_set   = (word == WW'(W_SET));
    assign hit_clr   = (word == WW'(W_CLR));
    assign hit_const = (word == WW'(W_CONST));
    assign cfg_off   = word - WW'(W_CFG);
    assign hit_cfg   = (word >= WW'(W_CFG)) && (cfg_off < WW'(NPINS));
    assign cfg_idx   = cfg_off[IW-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !we) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // outputs of the port machine
    always_comb begin
        ready  = 1'b0;
        rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: ready  = 1'b1;
            ST_RESP: rvalid = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_latch <= '0;
        end else if (accept && we && hit_set) begin
            out_latch <= out_latch | wdata[NPINS-1:0];
        end else if (accept && we && hit_clr) begin
            out_latch <= out_latch & ~wdata[NPINS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= pad_in;
    end

    gpio_cfg_store #(.NPINS(NPINS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept && we && hit_cfg),
        .wr_idx (cfg_idx),
        .wr_cfg (word_to_cfg(wdata)),
        .cfg    (cfg)
    );

    gpio_pad_ctl #(.NPINS(NPINS)) u_pad (
        .cfg     (cfg),
        .latch   (out_latch),
        .in_q    (in_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_od  (pad_od),
        .in_view (in_view)
    );

    always_comb begin
        rd_word = '0;
        if (hit_in)         rd_word = 64'(in_view);
        else if (hit_set)   rd_word = 64'(out_latch);
        else if (hit_const) rd_word = {48'd0, VEC_BASE, 8'(NPINS)};
        else if (hit_cfg)   rd_word = cfg_to_word(cfg[cfg_idx]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (accept && !we)    rdata_q <= rd_word;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NPINS = 64,
    parameter int AW    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             we,
    input logic             ready,
    input logic             rvalid,
    input logic [AW-1:0]    addr,
    input logic [63:0]      wdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_od,
    input logic [NPINS-1:0] latch
);

    logic wr_acc, is_set, is_clr;
    assign wr_acc = req && ready && we;
    assign is_set = (addr[AW-1:3] == (AW-3)'(1));
    assign is_clr = (addr[AW-1:3] == (AW-3)'(2));

    AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !we) |=> (rvalid && !ready)); // R12
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R12
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && is_set) |=> ((latch & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0]))); // R2
    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && is_clr) |=> ((latch & $past(wdata[NPINS-1:0])) == '0)); // R3
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(latch)); // R12
    AST_OD_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_od & pad_oe & pad_out) == '0)); // R9

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .ready   (ready),
    .rvalid  (rvalid),
    .addr    (addr),
    .wdata   (wdata),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_od  (pad_od),
    .latch   (out_latch)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int NPINS = 64;
    localparam int AW    = 12;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] CFG_MASK = 64'h0000_0000_03FF_100F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [63:0] wdata = '0;
    logic ready, rvalid;
    logic [63:0] rdata;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out, pad_oe, pad_od;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NPINS-1:0] m_latch;
    logic [63:0]      m_cfg [NPINS];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.NPINS(NPINS), .AW(AW), .VEC_BASE(8'd48)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rvalid(rvalid), .rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NPINS-1:0] exp_out();
        logic [NPINS-1:0] r;
        for (int p = 0; p < NPINS; p++) r[p] = m_latch[p] ^ m_cfg[p][1];
        return r;
    endfunction

    function automatic logic [NPINS-1:0] exp_od();
        logic [NPINS-1:0] r;
        for (int p = 0; p < NPINS; p++)
            r[p] = (m_cfg[p][25:16] == 0) && m_cfg[p][0] && m_cfg[p][12];
        return r;
    endfunction

    function automatic logic [NPINS-1:0] exp_oe();
        logic [NPINS-1:0] r;
        for (int p = 0; p < NPINS; p++)
            r[p] = (m_cfg[p][25:16] == 0) && m_cfg[p][0] &&
                   (!m_cfg[p][12] || !(m_latch[p] ^ m_cfg[p][1]));
        return r;
    endfunction

    task automatic check_pads(input string tag);
        chk({tag, " R7 pad_out"}, 64'(pad_out), 64'(exp_out()));
        chk({tag, " R8 R9 R10 pad_oe"}, 64'(pad_oe), 64'(exp_oe()));
        chk({tag, " R9 R10 pad_od"}, 64'(pad_od), 64'(exp_od()));
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
        int wi;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        wi = int'(a >> 3);
        if (wi == 1) m_latch = m_latch | d[NPINS-1:0];
        else if (wi == 2) m_latch = m_latch & ~d[NPINS-1:0];
        else if (wi >= 128 && wi < 128 + NPINS) m_cfg[wi-128] = d & CFG_MASK;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        chk("R12 rvalid after read", 64'(rvalid), 64'd1);
        chk("R12 ready low in response", 64'(ready), 64'd0);
        d = rdata;
    endtask

    function automatic logic [63:0] exp_input();
        logic [63:0] r = '0;
        for (int p = 0; p < NPINS; p++) r[p] = pad_in[p] ^ m_cfg[p][1];
        return r;
    endfunction

    initial begin
        logic [63:0] v;
        logic [AW-1:0] ca;
        void'($urandom(32'h5eed_1234));
        m_latch = '0;
        for (int p = 0; p < NPINS; p++) m_cfg[p] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ready", 64'(ready), 64'd1);
        chk("R1 rvalid", 64'(rvalid), 64'd0);
        chk("R1 pad_oe", 64'(pad_oe), 64'd0);
        chk("R1 pad_od", 64'(pad_od), 64'd0);
        chk("R1 pad_out", 64'(pad_out), 64'd0);
        rd(12'h008, v); chk("R1 latch", v, 64'd0);
        rd(12'h5F8, v); chk("R1 cfg", v, 64'd0);

        // R11 constants
        rd(12'h090, v); chk("R11 constants", v, 64'h3040);

        // R2 / R3 directed
        wr(12'h008, 64'hF0F0_0000_0000_00FF);
        rd(12'h008, v); chk("R2 set", v, 64'(m_latch));
        wr(12'h010, 64'h8000_0000_0000_000F);
        rd(12'h008, v); chk("R3 clear", v, 64'(m_latch));
        chk("R3 model", 64'(m_latch), 64'h70F0_0000_0000_00F0);
        rd(12'h010, v); chk("R4 clear reads zero", v, 64'd0);

        // R6 config fields, all ones written
        wr(12'h400 + 12'd8*12'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h400 + 12'd8*12'd5, v); chk("R6 cfg fields", v, 64'h03FF_100F);
        check_pads("R10 pin5 select");

        // R9 open drain on pin 4 (latch bit 4 = 1)
        wr(12'h420, 64'h0000_0000_0000_1001);
        check_pads("R9 od high");
        wr(12'h010, 64'h10);
        check_pads("R9 od low");
        wr(12'h420, 64'h0000_0000_0000_1003);
        check_pads("R9 od inverted");

        // R5 input register with polarity
        @(negedge clk); pad_in = 64'hDEAD_BEEF_0123_4567;
        @(posedge clk);
        rd(12'h000, v); chk("R5 input view", v, exp_input());

        // R12 request while not ready is ignored
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 12'h008;
        @(posedge clk);
        @(negedge clk);
        we = 1'b1; addr = 12'h008; wdata = '1;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        rd(12'h008, v); chk("R12 ignored while busy", v, 64'(m_latch));

        // R13 unmapped
        wr(12'h018, '1);
        wr(12'h000, '1);
        rd(12'h018, v); chk("R13 unmapped read", v, 64'd0);
        rd(12'h600, v); chk("R13 beyond pin count", v, 64'd0);
        rd(12'h008, v); chk("R13 latch unchanged", v, 64'(m_latch));

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            int pin;
            logic [63:0] rw;
            op  = int'($urandom_range(0, 5));
            pin = int'($urandom_range(0, NPINS-1));
            rw  = {$urandom(), $urandom()};
            ca  = AW'(12'h400 + 12'(pin) * 12'd8);
            case (op)
                0: wr(12'h008, rw);
                1: wr(12'h010, rw);
                2: begin
                    if ($urandom_range(0, 3) != 0) rw[25:16] = '0;
                    wr(ca, rw);
                end
                3: begin rd(ca, v); chk("R6 random cfg", v, m_cfg[pin]); end
                4: begin rd(12'h008, v); chk("R4 random latch", v, 64'(m_latch)); end
                default: begin
                    @(negedge clk); pad_in = rw[NPINS-1:0];
                    @(posedge clk);
                    rd(12'h000, v); chk("R5 random input", v, exp_input());
                end
            endcase
            check_pads("random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule